// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 peripheral interrupt request lines and turns them into the two interrupt inputs of a processor: an active-low fast interrupt line (`nfiq_o`) and an active-low normal interrupt line (`nirq_o`). Software decides at run time whether each source is a fast interrupt or a vectored normal interrupt. Each vectored source has its own 4-bit priority and its own 32-bit handler address. A pending fast interrupt always wins over every vectored source.

The handler reads the vector register and gets the address of the best pending enabled vectored source. That read also raises the current service level to the priority of that source. While the level is raised, only sources with a strictly better priority can pull `nirq_o` low, so nesting works without software masking. Any write to the vector register ends the current service and restores the level that was active before it. The levels are kept on a small stack. A software force register can inject requests alongside the hardware lines.

The register port is a simple single-cycle word port. Read data is combinational from the address, and the side effects of a read or a write take effect at the clock edge of the access.

Top module: `vintc_top`

## Requirements
- R1: After a synchronous active-low reset, `nfiq_o` and `nirq_o` are high and the following all read 0: enable (addr 0x03), type (0x05) and force (0x06). Every priority (0x20+n) resets to 15 and every vector (0x40+n) resets to 0.
- R2: The raw register (addr 0x00) shows the request inputs ORed with the force register, whatever the enables are.
- R3: A write to 0x03 sets the enable bits that are 1 in the data, and a write to 0x04 clears them. Zero bits in the data leave the enables unchanged. Reads at either address return the enables.
- R4: The type register (0x05) sends a source to the fast line when its bit is 1. The fast status register (0x02) shows raw & enable & type. `nfiq_o` is low one clock edge after any bit of that register is set, and high one edge after none is set.
- R5: The vectored status register (0x01) shows raw & enable & ~type. A source left disabled never lowers `nirq_o`.
- R6: While any enabled fast request is active, `nirq_o` stays high, even when vectored requests are eligible.
- R7: The winner among eligible vectored sources is the one with the smallest priority value. Ties go to the lower source number. Reading the vector register (0x07) returns the vector register of the winner.
- R8: A vector read that finds a winner raises the service level to the winner's priority. After that, `nirq_o` goes low only for sources whose priority is strictly smaller than the level.
- R9: Any write to 0x07 ends the current service and restores the previous level from the stack. A write when no service is active has no effect.
- R10: A vector read with no eligible source returns 0 and leaves the service level unchanged.
- R11: A 1 in the force register (0x06) acts like an active request line for that source.
- R12: Priority registers keep only 4 bits and read back with the upper bits 0. A new priority takes effect in arbitration at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (needed for the vector read side effect) |
| reg_addr_i | input | 8 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| irq_req_i | input | 32 | Peripheral request lines, active high |
| nfiq_o | output | 1 | Fast interrupt to the processor, active low |
| nirq_o | output | 1 | Normal interrupt to the processor, active low |

## Verification
The assertions check four things on every cycle:
- the two processor lines never both report an interrupt, because the fast line has precedence;
- the fast line follows enabled fast requests one edge later;
- the reported winner always sits strictly above the current service level, and an acknowledge loads that level;
- the level stack stays in range and pops exactly one entry on each end of interrupt.

Only the directed scenarios can show the rest:
- which source wins by priority and by number;
- which vector address is returned;
- that equal-priority requests are held off during service;
- how the set/clear enables, force bits and priority truncation work.

// File: rtl/vintc_pkg.sv
// Package: shared constants for the vectored interrupt controller.
// Assumes a word-addressed register port with an 8-bit address.
package vintc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // Fixed register addresses.
    localparam logic [ADDR_W-1:0] A_RAW   = 8'h00;
    localparam logic [ADDR_W-1:0] A_IRQST = 8'h01;
    localparam logic [ADDR_W-1:0] A_FIQST = 8'h02;
    localparam logic [ADDR_W-1:0] A_ENSET = 8'h03;
    localparam logic [ADDR_W-1:0] A_ENCLR = 8'h04;
    localparam logic [ADDR_W-1:0] A_TYPE  = 8'h05;
    localparam logic [ADDR_W-1:0] A_FORCE = 8'h06;
    localparam logic [ADDR_W-1:0] A_VECT  = 8'h07;

    // Per-source windows: upper 3 address bits select the window.
    localparam logic [2:0] W_PRIO = 3'b001;   // 0x20 + n
    localparam logic [2:0] W_VEC  = 3'b010;   // 0x40 + n
endpackage

// File: rtl/vintc_regs.sv
// Module: register file of the controller. Holds enables, type select,
// force bits, per-source priorities and vectors, and builds read data.
// Assumes NSRC <= 32 so each source fits a single data word and window.
module vintc_regs
    import vintc_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 4,
    parameter int VEC_W  = 32
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [DATA_W-1:0]             rdata_o,
    input  logic [NSRC-1:0]               raw_i,
    input  logic                          win_valid_i,
    input  logic [VEC_W-1:0]              win_vec_i,
    output logic [NSRC-1:0]               en_o,
    output logic [NSRC-1:0]               fiq_sel_o,
    output logic [NSRC-1:0]               force_o,
    output logic [NSRC-1:0][PRIO_W-1:0]   prio_o,
    output logic [NSRC-1:0][VEC_W-1:0]    vec_o
);
    localparam int IDX_W = 5;
    localparam logic [PRIO_W-1:0] PRIO_RST = '1;

    logic [IDX_W-1:0] idx;
    logic             in_prio_win;
    logic             in_vec_win;

    // Decode the per-source windows from the address.
    always_comb begin
        idx         = addr_i[IDX_W-1:0];
        in_prio_win = (addr_i[7:5] == W_PRIO) && (int'(idx) < NSRC);
        in_vec_win  = (addr_i[7:5] == W_VEC)  && (int'(idx) < NSRC);
    end

    // Enables: write-1-to-set and write-1-to-clear ports.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            en_o <= '0;
        else if (wr_i && addr_i == A_ENSET)
            en_o <= en_o | wdata_i[NSRC-1:0];
        else if (wr_i && addr_i == A_ENCLR)
            en_o <= en_o & ~wdata_i[NSRC-1:0];
    end

    // Type select and software force registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fiq_sel_o <= '0;
            force_o   <= '0;
        end else if (wr_i) begin
            if (addr_i == A_TYPE)  fiq_sel_o <= wdata_i[NSRC-1:0];
            if (addr_i == A_FORCE) force_o   <= wdata_i[NSRC-1:0];
        end
    end

    // One priority and one vector register per source.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // Load this source's priority or vector on a matching write.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                prio_o[g] <= PRIO_RST;
                vec_o[g]  <= '0;
            end else if (wr_i && int'(idx) == g) begin
                if (in_prio_win) prio_o[g] <= wdata_i[PRIO_W-1:0];
                if (in_vec_win)  vec_o[g]  <= wdata_i[VEC_W-1:0];
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        rdata_o = '0;
        if (in_prio_win)
            rdata_o = DATA_W'(prio_o[idx]);
        else if (in_vec_win)
            rdata_o = DATA_W'(vec_o[idx]);
        else begin
            case (addr_i)
                A_RAW:   rdata_o = DATA_W'(raw_i);
                A_IRQST: rdata_o = DATA_W'(raw_i & en_o & ~fiq_sel_o);
                A_FIQST: rdata_o = DATA_W'(raw_i & en_o & fiq_sel_o);
                A_ENSET,
                A_ENCLR: rdata_o = DATA_W'(en_o);
                A_TYPE:  rdata_o = DATA_W'(fiq_sel_o);
                A_FORCE: rdata_o = DATA_W'(force_o);
                A_VECT:  rdata_o = win_valid_i ? DATA_W'(win_vec_i) : '0;
                default: rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/vintc_arb.sv
// Module: priority arbiter for vectored sources. Chooses the pending
// source with the smallest priority value that is strictly below the
// current service level; ties go to the lowest source number.
// Assumes the level is one bit wider than a priority (idle = 2**PRIO_W).
module vintc_arb #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 4
) (
    input  logic [NSRC-1:0]             pend_i,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W:0]             level_i,
    output logic                        valid_o,
    output logic [$clog2(NSRC)-1:0]     idx_o,
    output logic [PRIO_W-1:0]           prio_o
);
    localparam int IDX_W = $clog2(NSRC);

    logic [NSRC-1:0] cand;

    // Keep only sources that would preempt the current level.
    for (genvar g = 0; g < NSRC; g++) begin : g_cand
        assign cand[g] = pend_i[g] && ({1'b0, prio_i[g]} < level_i);
    end

    // Scan downward so that equal priorities settle on the lowest number.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '1;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i] && (!valid_o || prio_i[i] <= prio_o)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/vintc_nest.sv
// Module: service-level stack. An acknowledge pushes the current level
// and loads the winner's priority; an end of interrupt pops it back.
// Assumes each push raises the level strictly, so depth never exceeds
// the number of priority values.
module vintc_nest #(
    parameter int PRIO_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ack_i,
    input  logic              eoi_i,
    input  logic [PRIO_W-1:0] win_prio_i,
    output logic [PRIO_W:0]   level_o,
    output logic [$clog2((1 << PRIO_W) + 1)-1:0] depth_o
);
    localparam int LEVELS = 1 << PRIO_W;
    localparam int SP_W   = $clog2(LEVELS + 1);
    localparam logic [PRIO_W:0] IDLE = (PRIO_W + 1)'(LEVELS);

    logic [LEVELS-1:0][PRIO_W:0] stack_q;

    // Push on acknowledge, pop on end of interrupt; acknowledge wins.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            level_o <= IDLE;
            depth_o <= '0;
            stack_q <= '0;
        end else if (ack_i && depth_o < SP_W'(LEVELS)) begin
            stack_q[depth_o[PRIO_W-1:0]] <= level_o;
            level_o <= {1'b0, win_prio_i};
            depth_o <= depth_o + 1'b1;
        end else if (eoi_i && depth_o != '0) begin
            level_o <= stack_q[depth_o[PRIO_W-1:0] - 1'b1];
            depth_o <= depth_o - 1'b1;
        end
    end
endmodule

// File: rtl/vintc_top.sv
// Module: vectored interrupt controller top. Merges hardware and forced
// requests, splits them into fast and vectored groups, arbitrates the
// vectored group against the service level and drives the active-low
// processor lines one clock after their cause.
// Assumes NSRC <= 32 and a single-cycle register port.
module vintc_top
    import vintc_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 4,
    parameter int VEC_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [7:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [31:0]       irq_req_i,
    output logic              nfiq_o,
    output logic              nirq_o
);
    localparam int IDX_W = $clog2(NSRC);
    localparam int SP_W  = $clog2((1 << PRIO_W) + 1);

    logic [NSRC-1:0]             raw, en, fiq_sel, force_bits;
    logic [NSRC-1:0]             irq_pend, fiq_pend;
    logic [NSRC-1:0][PRIO_W-1:0] prio_tbl;
    logic [NSRC-1:0][VEC_W-1:0]  vec_tbl;
    logic                        win_valid;
    logic [IDX_W-1:0]            win_idx;
    logic [PRIO_W-1:0]           win_prio;
    logic [VEC_W-1:0]            win_vec;
    logic [PRIO_W:0]             level;
    logic [SP_W-1:0]             depth;
    logic                        vec_ack, vec_eoi, fiq_any;

    // Request merge and split into fast and vectored groups.
    always_comb begin
        raw      = irq_req_i[NSRC-1:0] | force_bits;
        irq_pend = raw & en & ~fiq_sel;
        fiq_pend = raw & en & fiq_sel;
        fiq_any  = |fiq_pend;
        win_vec  = vec_tbl[win_idx];
        vec_ack  = reg_rd_i && reg_addr_i == A_VECT && win_valid;
        vec_eoi  = reg_wr_i && reg_addr_i == A_VECT;
    end

    vintc_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) i_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .raw_i      (raw),
        .win_valid_i(win_valid),
        .win_vec_i  (win_vec),
        .en_o       (en),
        .fiq_sel_o  (fiq_sel),
        .force_o    (force_bits),
        .prio_o     (prio_tbl),
        .vec_o      (vec_tbl)
    );

    vintc_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) i_arb (
        .pend_i (irq_pend),
        .prio_i (prio_tbl),
        .level_i(level),
        .valid_o(win_valid),
        .idx_o  (win_idx),
        .prio_o (win_prio)
    );

    vintc_nest #(.PRIO_W(PRIO_W)) i_nest (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ack_i     (vec_ack),
        .eoi_i     (vec_eoi),
        .win_prio_i(win_prio),
        .level_o   (level),
        .depth_o   (depth)
    );

    // Registered processor lines; fast requests hold the normal line off.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            nfiq_o <= 1'b1;
            nirq_o <= 1'b1;
        end else begin
            nfiq_o <= !fiq_any;
            nirq_o <= !(win_valid && !fiq_any);
        end
    end
endmodule

// File: rtl/vintc_chk.sv
// Module: assertion checker for vintc_top, attached by bind below.
// Assumes it sees the top's internal arbiter and stack signals.
module vintc_chk #(
    parameter int PRIO_W = 4,
    parameter int SP_W   = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              nfiq_o,
    input logic              nirq_o,
    input logic              fiq_any,
    input logic              vec_ack,
    input logic              vec_eoi,
    input logic              win_valid,
    input logic [PRIO_W-1:0] win_prio,
    input logic [PRIO_W:0]   level,
    input logic [SP_W-1:0]   depth
);
    localparam int LEVELS = 1 << PRIO_W;

    // The fast line has precedence over the normal line.
    assert_fiq_over_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !nfiq_o |-> nirq_o);

    // The fast line follows enabled fast requests one edge later.
    assert_fiq_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fiq_any |=> !nfiq_o);

    // The winner is always strictly above the service level.
    assert_win_above_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_valid |-> ({1'b0, win_prio} < level));

    // An acknowledge loads the winner's priority as the level.
    assert_ack_loads_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_ack |=> level == {1'b0, $past(win_prio)});

    // An end of interrupt pops exactly one stack entry.
    assert_eoi_pops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_eoi && !vec_ack && depth != '0) |=> depth == $past(depth) - 1'b1);

    // The stack depth stays within the number of levels.
    assert_depth_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        depth <= SP_W'(LEVELS));

    // A vector read without a winner leaves the level alone.
    assert_empty_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!vec_ack && !vec_eoi) |=> $stable(level));
endmodule

bind vintc_top vintc_chk #(.PRIO_W(PRIO_W), .SP_W(SP_W)) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .nfiq_o   (nfiq_o),
    .nirq_o   (nirq_o),
    .fiq_any  (fiq_any),
    .vec_ack  (vec_ack),
    .vec_eoi  (vec_eoi),
    .win_valid(win_valid),
    .win_prio (win_prio),
    .level    (level),
    .depth    (depth)
);

// File: tb/test_vintc_top.sv
// Bench: directed scenarios for vintc_top, one task each.
module test_vintc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [31:0] req = '0;
    logic        nfiq, nirq;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    vintc_top i_vintc_top (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_req_i(req), .nfiq_o(nfiq), .nirq_o(nirq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_w(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_r(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic do_reset();
        req = '0;
        @(negedge clk); rst_n = 1'b0;
        step(2); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset(); step(1);
        check("R1 nfiq", 32'(nfiq), 1);
        check("R1 nirq", 32'(nirq), 1);
        reg_r(8'h03, d); check("R1 enable", d, 0);
        reg_r(8'h05, d); check("R1 type", d, 0);
        reg_r(8'h06, d); check("R1 force", d, 0);
        reg_r(8'h27, d); check("R1 prio", d, 15);
        reg_r(8'h47, d); check("R1 vector", d, 0);
    endtask

    task automatic t_enable_type();
        logic [31:0] d;
        do_reset();
        req = 32'h0000_00F0; step(1);
        reg_r(8'h00, d); check("R2 raw", d, 32'h0000_00F0);
        check("R5 disabled nirq", 32'(nirq), 1);
        reg_w(8'h03, 32'h30); reg_w(8'h03, 32'h01);
        reg_r(8'h03, d); check("R3 set", d, 32'h31);
        reg_w(8'h04, 32'h10);
        reg_r(8'h04, d); check("R3 clear", d, 32'h21);
        reg_r(8'h01, d); check("R5 irq status", d, 32'h20);
        step(1); check("R5 nirq low", 32'(nirq), 0);
        reg_w(8'h05, 32'h20); step(1);
        reg_r(8'h02, d); check("R4 fiq status", d, 32'h20);
        reg_r(8'h01, d); check("R4 irq status", d, 0);
        check("R4 nfiq low", 32'(nfiq), 0);
        reg_w(8'h03, 32'h40); step(1);
        check("R6 nirq held", 32'(nirq), 1);
        req = 32'h0000_00D0; step(1);
        check("R4 nfiq high", 32'(nfiq), 1);
        check("R6 nirq released", 32'(nirq), 0);
    endtask

    task automatic setup_vectors();
        reg_w(8'h03, 32'hFFFF_FFFF);
        for (int i = 0; i < 16; i++) reg_w(8'h40 + 8'(i), 32'h1000 + 32'(i * 4));
        reg_w(8'h23, 5); reg_w(8'h27, 2); reg_w(8'h29, 2); reg_w(8'h21, 0);
    endtask

    task automatic t_arbitrate_nest();
        logic [31:0] d;
        do_reset(); setup_vectors();
        reg_r(8'h07, d); check("R10 empty read", d, 0);
        req = 32'h0000_0008; step(1);
        check("R10 level unchanged", 32'(nirq), 0);
        req = 32'h0000_0288; step(1);
        reg_r(8'h07, d); check("R7 winner tie", d, 32'h101C);
        step(1); check("R8 equal held off", 32'(nirq), 1);
        req = 32'h0000_028A; step(1);
        check("R8 higher preempts", 32'(nirq), 0);
        reg_r(8'h07, d); check("R8 nested vector", d, 32'h1004);
        reg_w(8'h07, 0); step(1);
        check("R9 pop to level 2", 32'(nirq), 0);
        req = 32'h0000_0288; step(1);
        check("R9 level 2 restored", 32'(nirq), 1);
        reg_w(8'h07, 0); step(1);
        check("R9 idle restored", 32'(nirq), 0);
        reg_w(8'h07, 0); step(1);
        check("R9 empty eoi", 32'(nirq), 0);
        reg_r(8'h07, d); check("R9 same winner", d, 32'h101C);
        reg_w(8'h07, 0);
    endtask

    task automatic t_force_prio();
        logic [31:0] d;
        do_reset(); setup_vectors();
        reg_w(8'h06, 32'h0000_1000); step(1);
        reg_r(8'h00, d); check("R11 raw force", d, 32'h0000_1000);
        check("R11 nirq", 32'(nirq), 0);
        reg_w(8'h2C, 3);
        req = 32'h0000_0080;
        reg_r(8'h07, d); check("R11 forced loses", d, 32'h101C);
        reg_w(8'h07, 0);
        reg_w(8'h24, 32'hFF);
        reg_r(8'h24, d); check("R12 truncated", d, 32'hF);
        reg_w(8'h2C, 1);
        reg_r(8'h07, d); check("R12 reprogram wins", d, 32'h1030);
        reg_w(8'h07, 0);
    endtask

    initial begin
        t_reset();
        t_enable_type();
        t_arbitrate_nest();
        t_force_prio();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule